// File: doc/BRIEF.md
# Synchronous Burst Write Controller for 16-bit Pseudo-SRAM

This block is the host side of a synchronous burst write into a 16-bit pseudo-SRAM. A user presents a start address and a beat count on a command handshake. The controller then opens a burst with one address cycle. It waits a configured number of latency cycles and then streams 16-bit words from a valid/ready data port onto the memory bus, one word per unstalled clock. Each word carries two byte enables, which become the active-low upper and lower byte masks.

The memory can stall any beat through its WAIT pin. Two configuration inputs set how that pin is read: its polarity, and whether it flags the stall in the affected cycle or one cycle earlier. The burst never wraps. The controller ends it by raising chip select after the last beat, holds chip select high for at least one clock, and signals completion with a one-cycle done pulse. A zero-length command starts no bus cycle and is answered with a reject pulse.

Top module: `psram_burst_wr`

## Requirements
- R1: During and right after reset, chip select, address valid and write enable are high (inactive), both byte masks are high, wd_ready, done and reject are low, and req_ready is high.
- R2: A command accepted with req_len ≥ 1 produces, in the next cycle, a single address cycle: mem_cs_n=0, mem_adv_n=0, mem_we_n=0 and mem_addr equal to the start address. mem_adv_n and mem_we_n are high in every later cycle of the burst.
- R3: Exactly cfg_latency cycles (0 to 7) separate the address cycle from the first data cycle. During those cycles chip select stays low and wd_ready stays low.
- R4: In an unstalled data cycle, wd_ready is 1 and mem_dq equals wd_data. mem_ub_n equals the inverse of wd_be[1], which governs bits 15 to 8, and mem_lb_n equals the inverse of wd_be[0], which governs bits 7 to 0.
- R5: An unstalled data cycle with wd_valid low still counts as a beat, with both byte masks high so that no byte is written.
- R6: With cfg_wait_hi=1 the WAIT pin is active when high. With cfg_wait_hi=0 it is active when low.
- R7: With cfg_wait_early=0, an active WAIT stalls the same data cycle. With cfg_wait_early=1, an active WAIT stalls the data cycle that follows.
- R8: In a stalled data cycle wd_ready is 0 and no beat is counted. Any number of consecutive stall cycles is accepted.
- R9: The burst carries exactly req_len counted beats. In the cycle after the last beat, chip select is high, done is high for one cycle and req_ready is low. Chip select stays high for at least that cycle.
- R10: A command with req_len=0 starts no bus cycle: chip select stays high and reject pulses for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; memory samples on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_hi | input | 1 | 1: WAIT active high, 0: active low |
| cfg_wait_early | input | 1 | 1: WAIT leads the affected beat by one cycle |
| cfg_latency | input | 3 | Cycles between address cycle and first data cycle |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Controller idle, command accepted |
| req_addr | input | 21 | Burst start address |
| req_len | input | 8 | Number of beats |
| wd_valid | input | 1 | Data word valid |
| wd_ready | output | 1 | Data word taken this cycle |
| wd_data | input | 16 | Data word |
| wd_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte mask, active low |
| mem_lb_n | output | 1 | Lower byte mask, active low |
| mem_addr | output | 21 | Memory address |
| mem_dq | output | 16 | Memory write data |
| mem_wait | input | 1 | Memory stall indication |
| done | output | 1 | Burst finished pulse |
| reject | output | 1 | Zero-length command pulse |

## Verification
The assertions check, on every cycle, the shape of the control pins. Address valid is a single-cycle pulse that always comes with chip select and write enable. No word is taken in a stalled cycle. Chip select rising always coincides with done and is followed by another high cycle. Chip select is never low alongside a reject or a masked-off idle bus. Only the bench scenarios can show the counted properties: the latency gap, the number of beats per burst, the one-cycle lead of early WAIT, and the correct data and masks per beat. These depend on a cycle-by-cycle expectation the bench builds from the command and the injected WAIT pattern.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_LAT,
    S_DATA,
    S_END
  } wr_state_e;

  // decode the raw WAIT pin into "stall requested"
  function automatic logic wait_is_active(input logic raw, input logic act_high);
    return act_high ? raw : ~raw;
  endfunction

  // active-low byte masks for one beat; no valid word writes nothing
  function automatic logic [1:0] beat_masks_n(input logic vld, input logic [1:0] be);
    return vld ? ~be : 2'b11;
  endfunction

endpackage

// File: rtl/psram_wr_wait.sv
module psram_wr_wait
  import psram_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_wait,
  input  logic cfg_wait_hi,
  input  logic cfg_wait_early,
  input  logic in_data,
  output logic stall
);

  logic wait_now;
  logic wait_q;

  assign wait_now = wait_is_active(mem_wait, cfg_wait_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_now;
  end

  assign stall = in_data & (cfg_wait_early ? wait_q : wait_now);

  p_stall_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> in_data);

  p_early_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && cfg_wait_early && $past(cfg_wait_early) && $past(wait_now)) |-> stall);

  p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !cfg_wait_early && (mem_wait == cfg_wait_hi)) |-> stall);

endmodule

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              stall,
  output logic              req_ready,
  output logic              wd_ready,
  output logic              in_data,
  output logic              cs_n,
  output logic              adv_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              done,
  output logic              reject
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  wr_state_e         st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rej_q, rej_d;
  logic              take;

  assign req_ready = (st_q == S_IDLE);
  assign in_data   = (st_q == S_DATA);
  assign take      = in_data & ~stall;
  assign wd_ready  = take;
  assign cs_n      = ~((st_q == S_ADDR) | (st_q == S_LAT) | (st_q == S_DATA));
  assign adv_n     = (st_q != S_ADDR);
  assign we_n      = (st_q != S_ADDR);
  assign addr_out  = addr_q;
  assign done      = (st_q == S_END);
  assign reject    = rej_q;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    lat_d  = lat_q;
    addr_d = addr_q;
    rej_d  = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        if (req_len == '0) rej_d = 1'b1;
        else begin
          st_d   = S_ADDR;
          rem_d  = req_len;
          addr_d = req_addr;
        end
      end
      S_ADDR: begin
        if (cfg_latency == '0) st_d = S_DATA;
        else begin
          st_d  = S_LAT;
          lat_d = cfg_latency - LAT_W'(1);
        end
      end
      S_LAT: begin
        if (lat_q == '0) st_d = S_DATA;
        else             lat_d = lat_q - LAT_W'(1);
      end
      S_DATA: if (take) begin
        rem_d = rem_q - LEN_ONE;
        if (rem_q == LEN_ONE) st_d = S_END;
      end
      S_END:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      lat_q  <= '0;
      addr_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      lat_q  <= lat_d;
      addr_q <= addr_d;
      rej_q  <= rej_d;
    end
  end

  p_adv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> adv_n);

  p_addr_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> (!cs_n && !we_n));

  p_cs_rise_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  p_beats_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (rem_q != '0));

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> cs_n);

endmodule

// File: rtl/psram_burst_wr.sv
module psram_burst_wr
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wait_hi,
  input  logic              cfg_wait_early,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [1:0]        wd_be,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq,
  input  logic              mem_wait,
  output logic              done,
  output logic              reject
);

  logic       stall;
  logic       in_data;
  logic [1:0] masks_n;

  psram_wr_wait u_wait (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_wait       (mem_wait),
    .cfg_wait_hi    (cfg_wait_hi),
    .cfg_wait_early (cfg_wait_early),
    .in_data        (in_data),
    .stall          (stall)
  );

  psram_wr_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .LAT_W  (LAT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .cfg_latency (cfg_latency),
    .stall       (stall),
    .req_ready   (req_ready),
    .wd_ready    (wd_ready),
    .in_data     (in_data),
    .cs_n        (mem_cs_n),
    .adv_n       (mem_adv_n),
    .we_n        (mem_we_n),
    .addr_out    (mem_addr),
    .done        (done),
    .reject      (reject)
  );

  assign masks_n  = in_data ? beat_masks_n(wd_valid, wd_be) : 2'b11;
  assign mem_ub_n = masks_n[1];
  assign mem_lb_n = masks_n[0];
  assign mem_dq   = in_data ? wd_data : '0;

  p_no_take_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !wd_ready);

  p_masks_off_no_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && !wd_valid) |-> (mem_ub_n && mem_lb_n));

  p_idle_bus_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_ub_n && mem_lb_n && !wd_ready));

  p_latency_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && mem_adv_n && !in_data) |-> !wd_ready);

endmodule

// File: tb/tb_psram_burst_wr.sv
module tb_psram_burst_wr;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [20:0] addr;
    logic [7:0]  len;
    logic [2:0]  lat;
    logic        pol;
    logic        early;
    logic [7:0]  st_at;
    logic [7:0]  st_n;
    logic [7:0]  gap;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{21'h012345, 8'd4, 3'd2, 1'b0, 1'b0, 8'd255, 8'd0, 8'd255},
    '{21'h1FFFFF, 8'd6, 3'd3, 1'b1, 1'b0, 8'd2,   8'd3, 8'd255},
    '{21'h000010, 8'd5, 3'd1, 1'b0, 1'b1, 8'd0,   8'd2, 8'd255},
    '{21'h0ABCDE, 8'd3, 3'd0, 1'b1, 1'b1, 8'd1,   8'd1, 8'd255},
    '{21'h055555, 8'd1, 3'd4, 1'b0, 1'b0, 8'd0,   8'd4, 8'd255}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wait_hi = 1'b0;
  logic        cfg_wait_early = 1'b0;
  logic [2:0]  cfg_latency = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [15:0] wd_data = '0;
  logic [1:0]  wd_be = '0;
  logic        mem_cs_n, mem_adv_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [20:0] mem_addr;
  logic [15:0] mem_dq;
  logic        mem_wait = 1'b1;
  logic        done, reject;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_burst_wr dut (
    .clk(clk), .rst_n(rst_n), .cfg_wait_hi(cfg_wait_hi), .cfg_wait_early(cfg_wait_early),
    .cfg_latency(cfg_latency), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_be(wd_be), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_wait(mem_wait), .done(done), .reject(reject)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit stall_at(input vec_t v, input int k);
    return (k >= 0) && (k >= int'(v.st_at)) && (k < int'(v.st_at) + int'(v.st_n));
  endfunction

  function automatic logic [15:0] word_of(input logic [20:0] a, input int b);
    return {a[7:0] + 8'(b), 8'(b) ^ 8'hA5};
  endfunction

  function automatic logic [1:0] be_of(input int b);
    return 2'(b + 3);
  endfunction

  task automatic drive_wait(input vec_t v, input int k);
    bit act;
    act = v.early ? stall_at(v, k + 1) : stall_at(v, k);
    mem_wait = v.pol ? act : ~act;
  endtask

  task automatic run_burst(input vec_t v);
    int k;
    int b;
    cfg_wait_hi    = v.pol;
    cfg_wait_early = v.early;
    cfg_latency    = v.lat;
    @(negedge clk);
    mem_wait  = ~v.pol;
    req_valid = 1'b1;
    req_addr  = v.addr;
    req_len   = v.len;
    @(negedge clk);
    req_valid = 1'b0;
    k = -(int'(v.lat) + 1);
    drive_wait(v, k);
    #1;
    chk(!mem_cs_n && !mem_adv_n && !mem_we_n, "R2", "addr cycle ctrl",
        {mem_cs_n, mem_adv_n, mem_we_n}, 3'b000);
    chk(mem_addr == v.addr, "R2", "addr value", mem_addr, v.addr);
    for (int i = 0; i < int'(v.lat); i++) begin
      @(negedge clk);
      k++;
      drive_wait(v, k);
      #1;
      chk(!mem_cs_n && mem_adv_n && mem_we_n && !wd_ready, "R3", "latency cycle",
          {mem_cs_n, mem_adv_n, mem_we_n, wd_ready}, 4'b0110);
    end
    b = 0;
    k = 0;
    while (b < int'(v.len) && k < 2000) begin
      @(negedge clk);
      drive_wait(v, k);
      wd_valid = (b != int'(v.gap));
      wd_data  = word_of(v.addr, b);
      wd_be    = be_of(b);
      #1;
      if (stall_at(v, k)) begin
        chk(!wd_ready && !mem_cs_n, "R8", "stalled cycle", {mem_cs_n, wd_ready}, 2'b00);
      end else begin
        chk(wd_ready && !mem_cs_n && mem_adv_n && mem_we_n, "R4", "data cycle ctrl",
            {mem_cs_n, mem_adv_n, mem_we_n, wd_ready}, 4'b0111);
        chk(mem_dq == word_of(v.addr, b), "R4", "data value", mem_dq, word_of(v.addr, b));
        if (b == int'(v.gap))
          chk(mem_ub_n && mem_lb_n, "R5", "masks without word", {mem_ub_n, mem_lb_n}, 2'b11);
        else
          chk({mem_ub_n, mem_lb_n} == ~be_of(b), "R4", "byte masks",
              {mem_ub_n, mem_lb_n}, ~be_of(b));
        b++;
      end
      k++;
    end
    @(negedge clk);
    mem_wait = ~v.pol;
    wd_valid = 1'b0;
    #1;
    chk(mem_cs_n && done && !req_ready, "R9", "end cycle",
        {mem_cs_n, done, req_ready}, 3'b110);
    @(negedge clk);
    #1;
    chk(mem_cs_n && !done && req_ready, "R9", "back to idle",
        {mem_cs_n, done, req_ready}, 3'b101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    #1;
    chk(mem_cs_n && mem_adv_n && mem_we_n && mem_ub_n && mem_lb_n, "R1", "pins in reset",
        {mem_cs_n, mem_adv_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && !wd_ready && !done && !reject && mem_cs_n, "R1", "after reset",
        {req_ready, wd_ready, done, reject, mem_cs_n}, 5'b10001);

    // R6 R7 R8 across polarity and timing mode via the table
    for (int i = 0; i < NV; i++) run_burst(VECS[i]);

    // R5: a beat with no valid word
    v = '{21'h000777, 8'd3, 3'd2, 1'b1, 1'b0, 8'd255, 8'd0, 8'd1};
    run_burst(v);

    // R8: long stall in early mode, active-high
    v = '{21'h100000, 8'd2, 3'd1, 1'b1, 1'b1, 8'd1, 8'd20, 8'd255};
    run_burst(v);

    // R10: zero-length command
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = 8'd0;
    req_addr  = 21'h0BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(reject && mem_cs_n && mem_adv_n && req_ready, "R10", "reject cycle",
        {reject, mem_cs_n, mem_adv_n, req_ready}, 4'b1111);
    @(negedge clk);
    #1;
    chk(!reject && mem_cs_n && mem_adv_n, "R10", "no bus after reject",
        {reject, mem_cs_n, mem_adv_n}, 3'b011);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule